// File: doc/BRIEF.md
# Palette and Page-Mapper Register Set

This block holds the colour and memory-paging registers of a home-computer style video and memory controller. The CPU writes to it through I/O cycles whose address bit 15 is low. The two top data bits of the written byte choose one of four functions: pick a palette slot, load colour data into the slot picked last, load the mode register (which also carries the CAPS LED), or load the RAM banking registers.

The palette has sixteen ink slots and one border slot. Each slot holds six bits: two bits each for red, green and blue. A video read port looks up a slot at any time. In the ordinary colour mode, a five-bit colour number is turned into levels 0 to 2 per channel. In the extended (mapper) mode, the six data bits are stored as they are. The paging side splits the 64 KB CPU space into four 16 KB pages. Each page has a six-bit block register, and these registers form the physical address.

The mapper-mode input selects how a banking write acts. In mapper mode, one page is updated. In compatible mode, all four pages are reloaded at once from a fixed eight-entry layout of 128 KB expansion style.

Top module: `palMapRegs`

## Requirements
- R1: After reset, every palette slot reads 0, the index register is 0, the mode register is 0 (capsLed low, modeCfg 0), and page k maps to block k.
- R2: An I/O write with ioAddr15 = 1, or any cycle with ioWr low, changes no palette slot, page register or mode output.
- R3: A write with data[7:6] = 00 stores data[4:0] as the current index. Index 0..15 addresses ink slot 0..15, and 16..31 all address the single border slot. On the read port, palRdIdx 16..31 likewise returns the border slot.
- R4: A write with data[7:6] = 01 loads the slot chosen by the last index write. The index is kept, so further data writes go to the same slot.
- R5: With mapperMode low, colour number n = data[4:0] is converted as follows. For n ≤ 26, G = n/9, R = (n/3) mod 3 and B = n mod 3. For n ≥ 27, all three levels are 0. The slot stores {R,G,B} in bits 5:4, 3:2 and 1:0, so level 3 never appears.
- R6: With mapperMode high, a palette data write stores data[5:0] unchanged as {R,G,B}.
- R7: A write with data[7:6] = 10 stores data[5:0] in the mode register. capsLed shows bit 5 and modeCfg shows bits 4..0.
- R8: With mapperMode high, a write with data[7:6] = 11 sets the block of page ioAddrPage to data[5:0]. The other three pages are unchanged.
- R9: With mapperMode low, a write with data[7:6] = 11 reloads all four pages from cfg = data[2:0] and bank b = data[5:3]. Let E_k = 4 + 4·b + k. The pages 0..3 then become:
  - cfg 0: 0,1,2,3
  - cfg 1: 0,1,2,E_3
  - cfg 2: E_0,E_1,E_2,E_3
  - cfg 3: 0,3,2,E_3
  - cfg 4..7: 0,E_(cfg−4),2,3
- R10: physAddr is {block of page cpuAddr[15:14], cpuAddr[13:0]}, combinationally.
- R11: A register write is visible on palRgb and physAddr from the cycle after its clock edge. In the write cycle itself, the old value is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ioWr | input | 1 | I/O write strobe, one cycle per write |
| ioAddr15 | input | 1 | I/O address bit 15; the block responds only when 0 |
| ioAddrPage | input | 2 | I/O address bits 9..8, the page for a mapper-mode banking write |
| ioData | input | 8 | I/O write data; bits 7..6 select the function |
| mapperMode | input | 1 | 1 = extended colour and per-page banking, 0 = compatible |
| palRdIdx | input | 5 | Palette slot to read for video |
| cpuAddr | input | 16 | CPU memory address to translate |
| palRgb | output | 6 | Colour of the slot at palRdIdx, {R,G,B} two bits each |
| capsLed | output | 1 | CAPS LED drive, mode register bit 5 |
| modeCfg | output | 5 | Mode register bits 4..0 |
| physAddr | output | 20 | Translated address {block, cpuAddr[13:0]} |

## Verification
Two functions can fall in the same cycle: a register write, and a combinational lookup through that same register. A bank write can arrive while cpuAddr points into the page being changed. A palette data write can arrive while palRdIdx reads the slot being loaded. The bench provokes both. It holds the write and the read together before the clock edge and expects the old value. It then samples just after the edge and expects the new value, while the write strobe is still high.

// File: rtl/palMapPkg.sv
package palMapPkg;
  parameter int IDX_W       = 5;
  parameter int NUM_INKS    = 16;
  parameter int PAL_ENTRIES = NUM_INKS + 1;
  parameter int BORDER_SLOT = NUM_INKS;
  parameter int SLOT_W      = $clog2(PAL_ENTRIES);
  parameter int CH_W        = 2;
  parameter int RGB_W       = 3 * CH_W;
  parameter int PAGE_BITS   = 2;
  parameter int NUM_PAGES   = 1 << PAGE_BITS;
  parameter int OFS_W       = 14;
  parameter int BLK_W       = 6;
  parameter int PHYS_W      = BLK_W + OFS_W;
  parameter int CPU_W       = PAGE_BITS + OFS_W;
  parameter int CFG_W       = 3;
  parameter int BANK_W      = 3;
  parameter int PAYLOAD_W   = 6;
  parameter int DATA_W      = 8;
  parameter int MODE_W      = PAYLOAD_W;
  parameter int LEVELS      = 3;

  typedef enum logic [1:0] {
    FN_INDEX = 2'b00,
    FN_INK   = 2'b01,
    FN_MODE  = 2'b10,
    FN_BANK  = 2'b11
  } ioFunc_t;

  typedef struct packed {
    logic                  idxWr;
    logic                  inkWr;
    logic                  modeWr;
    logic                  bankWr;
    logic                  mapMode;
    logic [PAGE_BITS-1:0]  pageSel;
    logic [PAYLOAD_W-1:0]  payload;
  } regStrobes_t;

  // Colour number -> three base-3 digits, G most significant.
  function automatic logic [RGB_W-1:0] compatColour(input logic [IDX_W-1:0] n);
    int v, r, g, b;
    v = int'(n);
    if (v >= LEVELS * LEVELS * LEVELS) return '0;
    g = v / (LEVELS * LEVELS);
    r = (v / LEVELS) % LEVELS;
    b = v % LEVELS;
    return {CH_W'(r), CH_W'(g), CH_W'(b)};
  endfunction

  // Whole-map layout for compatible banking mode.
  function automatic logic [BLK_W-1:0] compatBlock(input logic [CFG_W-1:0] cfg,
                                                   input logic [BANK_W-1:0] bank,
                                                   input int page);
    int ext, blk;
    ext = NUM_PAGES + NUM_PAGES * int'(bank);
    case (cfg)
      3'd0:    blk = page;
      3'd1:    blk = (page == NUM_PAGES-1) ? ext + NUM_PAGES-1 : page;
      3'd2:    blk = ext + page;
      3'd3:    blk = (page == 1) ? NUM_PAGES-1 : ((page == NUM_PAGES-1) ? ext + NUM_PAGES-1 : page);
      default: blk = (page == 1) ? ext + int'(cfg) - NUM_PAGES : page;
    endcase
    return BLK_W'(blk);
  endfunction

  function automatic logic [SLOT_W-1:0] slotOf(input logic [IDX_W-1:0] idx);
    return (int'(idx) >= NUM_INKS) ? SLOT_W'(BORDER_SLOT) : SLOT_W'(idx);
  endfunction
endpackage

// File: rtl/palMapCtrl.sv
module palMapCtrl
  import palMapPkg::*;
(
  input  logic                 ioWr,
  input  logic                 ioAddr15,
  input  logic [PAGE_BITS-1:0] ioAddrPage,
  input  logic [DATA_W-1:0]    ioData,
  input  logic                 mapperMode,
  output regStrobes_t          strobes
);
  ioFunc_t fn;
  logic    hit;

  always_comb begin
    fn  = ioFunc_t'(ioData[DATA_W-1 -: 2]);
    hit = ioWr && !ioAddr15;
    strobes.idxWr   = hit && (fn == FN_INDEX);
    strobes.inkWr   = hit && (fn == FN_INK);
    strobes.modeWr  = hit && (fn == FN_MODE);
    strobes.bankWr  = hit && (fn == FN_BANK);
    strobes.mapMode = mapperMode;
    strobes.pageSel = ioAddrPage;
    strobes.payload = ioData[PAYLOAD_W-1:0];
  end
endmodule

// File: rtl/palMapData.sv
module palMapData
  import palMapPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  regStrobes_t        strobes,
  input  logic [IDX_W-1:0]   palRdIdx,
  input  logic [CPU_W-1:0]   cpuAddr,
  output logic [RGB_W-1:0]   palRgb,
  output logic               capsLed,
  output logic [MODE_W-2:0]  modeCfg,
  output logic [PHYS_W-1:0]  physAddr
);
  logic [IDX_W-1:0]  curIdx;
  logic [RGB_W-1:0]  palMem [PAL_ENTRIES];
  logic [RGB_W-1:0]  inkValue;
  logic [MODE_W-1:0] modeReg;
  logic [NUM_PAGES-1:0][BLK_W-1:0] pageBlk;
  logic [NUM_PAGES-1:0][BLK_W-1:0] compatNext;
  logic [CFG_W-1:0]  cfgSel;
  logic [BANK_W-1:0] bankSel;

  assign inkValue = strobes.mapMode ? strobes.payload[RGB_W-1:0]
                                    : compatColour(strobes.payload[IDX_W-1:0]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curIdx <= '0;
      for (int i = 0; i < PAL_ENTRIES; i++) palMem[i] <= '0;
    end else begin
      if (strobes.idxWr) curIdx <= strobes.payload[IDX_W-1:0];
      if (strobes.inkWr) palMem[slotOf(curIdx)] <= inkValue;
    end
  end

  assign palRgb = palMem[slotOf(palRdIdx)];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               modeReg <= '0;
    else if (strobes.modeWr) modeReg <= strobes.payload[MODE_W-1:0];
  end

  assign capsLed = modeReg[MODE_W-1];
  assign modeCfg = modeReg[MODE_W-2:0];

  assign cfgSel  = strobes.payload[CFG_W-1:0];
  assign bankSel = strobes.payload[CFG_W +: BANK_W];

  for (genvar p = 0; p < NUM_PAGES; p++) begin : gCompat
    assign compatNext[p] = compatBlock(cfgSel, bankSel, p);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int p = 0; p < NUM_PAGES; p++) pageBlk[p] <= BLK_W'(p);
    end else if (strobes.bankWr) begin
      for (int p = 0; p < NUM_PAGES; p++) begin
        if (!strobes.mapMode)
          pageBlk[p] <= compatNext[p];
        else if (strobes.pageSel == PAGE_BITS'(p))
          pageBlk[p] <= strobes.payload[BLK_W-1:0];
      end
    end
  end

  assign physAddr = {pageBlk[cpuAddr[CPU_W-1:OFS_W]], cpuAddr[OFS_W-1:0]};
endmodule

// File: rtl/palMapRegs.sv
module palMapRegs
  import palMapPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 ioWr,
  input  logic                 ioAddr15,
  input  logic [PAGE_BITS-1:0] ioAddrPage,
  input  logic [DATA_W-1:0]    ioData,
  input  logic                 mapperMode,
  input  logic [IDX_W-1:0]     palRdIdx,
  input  logic [CPU_W-1:0]     cpuAddr,
  output logic [RGB_W-1:0]     palRgb,
  output logic                 capsLed,
  output logic [MODE_W-2:0]    modeCfg,
  output logic [PHYS_W-1:0]    physAddr
);
  regStrobes_t strobes;

  palMapCtrl ctrl_i (
    .ioWr(ioWr), .ioAddr15(ioAddr15), .ioAddrPage(ioAddrPage),
    .ioData(ioData), .mapperMode(mapperMode), .strobes(strobes)
  );

  palMapData data_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .palRdIdx(palRdIdx),
    .cpuAddr(cpuAddr), .palRgb(palRgb), .capsLed(capsLed),
    .modeCfg(modeCfg), .physAddr(physAddr)
  );
endmodule

// File: rtl/palMapRegsChk.sv
module palMapRegsChk
  import palMapPkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 ioWr,
  input logic                 ioAddr15,
  input logic [PAGE_BITS-1:0] ioAddrPage,
  input logic [DATA_W-1:0]    ioData,
  input logic                 mapperMode,
  input logic [CPU_W-1:0]     cpuAddr,
  input logic                 capsLed,
  input logic [MODE_W-2:0]    modeCfg,
  input logic [PHYS_W-1:0]    physAddr
);
  logic wrHit, bankHit, modeHit;
  assign wrHit   = ioWr && !ioAddr15;
  assign bankHit = wrHit && (ioData[7:6] == 2'b11);
  assign modeHit = wrHit && (ioData[7:6] == 2'b10);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    (rstN && !$past(rstN)) |-> (!capsLed && modeCfg == '0 &&
      physAddr[PHYS_W-1:OFS_W] == BLK_W'(cpuAddr[CPU_W-1:OFS_W])));

  // R2
  no_write_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrHit |=> ($stable(capsLed) && $stable(modeCfg)));

  // R7
  mode_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeHit |=> (capsLed == $past(ioData[5]) && modeCfg == $past(ioData[4:0])));

  // R8
  page_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bankHit && mapperMode) |=>
      (cpuAddr[CPU_W-1:OFS_W] != $past(ioAddrPage) ||
       physAddr[PHYS_W-1:OFS_W] == $past(ioData[BLK_W-1:0])));

  // R9
  ext_all_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bankHit && !mapperMode && ioData[2:0] == 3'd2) |=>
      (physAddr[PHYS_W-1:OFS_W] == 6'd4 + {1'b0, $past(ioData[5:3]), 2'b00}
                                   + {4'b0, cpuAddr[CPU_W-1:OFS_W]}));

  // R10
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    physAddr[OFS_W-1:0] == cpuAddr[OFS_W-1:0]);
endmodule

bind palMapRegs palMapRegsChk chk_i (
  .clk(clk), .rstN(rstN), .ioWr(ioWr), .ioAddr15(ioAddr15),
  .ioAddrPage(ioAddrPage), .ioData(ioData), .mapperMode(mapperMode),
  .cpuAddr(cpuAddr), .capsLed(capsLed), .modeCfg(modeCfg), .physAddr(physAddr)
);

// File: tb/palMapRegs_tb_top.sv
`timescale 1ns/1ps
module palMapRegs_tb_top;
  logic        clk = 0;
  logic        rstN = 0;
  logic        ioWr = 0;
  logic        ioAddr15 = 0;
  logic [1:0]  ioAddrPage = 0;
  logic [7:0]  ioData = 0;
  logic        mapperMode = 0;
  logic [4:0]  palRdIdx = 0;
  logic [15:0] cpuAddr = 0;
  logic [5:0]  palRgb;
  logic        capsLed;
  logic [4:0]  modeCfg;
  logic [19:0] physAddr;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [5:0] expPal [17];
  logic [5:0] expPage [4];
  logic [4:0] mIdx;
  logic [5:0] mMode;

  always #4 clk = ~clk;

  palMapRegs dut_i (
    .clk(clk), .rstN(rstN), .ioWr(ioWr), .ioAddr15(ioAddr15),
    .ioAddrPage(ioAddrPage), .ioData(ioData), .mapperMode(mapperMode),
    .palRdIdx(palRdIdx), .cpuAddr(cpuAddr), .palRgb(palRgb),
    .capsLed(capsLed), .modeCfg(modeCfg), .physAddr(physAddr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] expColour(input int n);
    int r, g, b;
    if (n > 26) return 6'd0;
    g = n / 9; r = (n / 3) % 3; b = n % 3;
    return {r[1:0], g[1:0], b[1:0]};
  endfunction

  function automatic logic [5:0] expBlk(input int c, input int b, input int p);
    int e;
    e = 4 + 4 * b;
    case (c)
      0: return 6'(p);
      1: return (p == 3) ? 6'(e + 3) : 6'(p);
      2: return 6'(e + p);
      3: return (p == 1) ? 6'd3 : ((p == 3) ? 6'(e + 3) : 6'(p));
      default: return (p == 1) ? 6'(e + c - 4) : 6'(p);
    endcase
  endfunction

  function automatic int slot(input logic [4:0] i);
    return (i >= 16) ? 16 : int'(i);
  endfunction

  task automatic modelApply(input logic a15, input logic [1:0] pg, input logic [7:0] d);
    if (!a15) begin
      case (d[7:6])
        2'b00: mIdx = d[4:0];
        2'b01: expPal[slot(mIdx)] = mapperMode ? d[5:0] : expColour(int'(d[4:0]));
        2'b10: mMode = d[5:0];
        default: begin
          if (mapperMode) expPage[pg] = d[5:0];
          else for (int p = 0; p < 4; p++) expPage[p] = expBlk(int'(d[2:0]), int'(d[5:3]), p);
        end
      endcase
    end
  endtask

  task automatic ioWrite(input logic a15, input logic [1:0] pg, input logic [7:0] d);
    @(negedge clk);
    ioWr = 1; ioAddr15 = a15; ioAddrPage = pg; ioData = d;
    @(negedge clk);
    ioWr = 0; ioAddr15 = 0;
    modelApply(a15, pg, d);
  endtask

  task automatic verifyPages(input string req, input logic [13:0] ofs);
    for (int p = 0; p < 4; p++) begin
      cpuAddr = {p[1:0], ofs};
      #1;
      chk(req, 32'(physAddr), 32'({expPage[p], ofs}));
    end
  endtask

  task automatic verifyAll(input string req);
    for (int i = 0; i < 32; i++) begin
      palRdIdx = 5'(i);
      #1;
      chk(req, 32'(palRgb), 32'(expPal[slot(5'(i))]));
    end
    verifyPages(req, 14'h1A5C);
    chk(req, 32'(capsLed), 32'(mMode[5]));
    chk(req, 32'(modeCfg), 32'(mMode[4:0]));
  endtask

  initial begin
    for (int i = 0; i < 17; i++) expPal[i] = '0;
    for (int p = 0; p < 4; p++) expPage[p] = 6'(p);
    mIdx = '0; mMode = '0;

    repeat (4) @(negedge clk);
    rstN = 1;
    verifyAll("R1");

    // R5: every colour number in compatible mode
    mapperMode = 0;
    for (int n = 0; n < 32; n++) begin
      ioWrite(0, 0, {3'b000, 5'(n % 16)});
      ioWrite(0, 0, {3'b010, 5'(n)});
      palRdIdx = 5'(n % 16);
      #1;
      chk("R5", 32'(palRgb), 32'(expColour(n)));
    end

    // R3: indices 16..31 all reach the border slot
    for (int i = 16; i < 32; i++) begin
      ioWrite(0, 0, {3'b000, 5'(i)});
      ioWrite(0, 0, {3'b010, 5'((i * 7) % 27)});
      palRdIdx = 5'(16); #1;
      chk("R3", 32'(palRgb), 32'(expColour((i * 7) % 27)));
      palRdIdx = 5'(31 - (i - 16)); #1;
      chk("R3", 32'(palRgb), 32'(expColour((i * 7) % 27)));
    end
    verifyAll("R3");

    // R4: index persists over two data writes
    ioWrite(0, 0, 8'h07);
    ioWrite(0, 0, {3'b010, 5'd3});
    ioWrite(0, 0, {3'b010, 5'd20});
    verifyAll("R4");

    // R6: raw six-bit colours in mapper mode
    mapperMode = 1;
    ioWrite(0, 0, 8'h09);
    for (int v = 0; v < 64; v++) begin
      ioWrite(0, 0, {2'b01, 6'(v)});
      palRdIdx = 5'd9; #1;
      chk("R6", 32'(palRgb), 32'(v));
    end

    // R7: mode register
    for (int k = 0; k < 6; k++) begin
      logic [5:0] mv;
      mv = 6'((k * 23 + 5) % 64);
      ioWrite(0, 0, {2'b10, mv});
      #1;
      chk("R7", 32'(capsLed), 32'(mv[5]));
      chk("R7", 32'(modeCfg), 32'(mv[4:0]));
    end

    // R8: per-page loads in mapper mode
    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < 4; k++) begin
        ioWrite(0, 2'(p), {2'b11, 6'((p * 17 + k * 11 + 9) % 64)});
        verifyPages("R8", 14'h0123);
      end
    end

    // R10: offset bits pass through
    verifyPages("R10", 14'h0000);
    verifyPages("R10", 14'h3FFF);
    verifyPages("R10", 14'h2AAA);

    // R9: all layouts and banks in compatible mode
    mapperMode = 0;
    for (int c = 0; c < 8; c++) begin
      for (int b = 0; b < 8; b++) begin
        ioWrite(0, 2'((c + b) % 4), {2'b11, 3'(b), 3'(c)});
        verifyPages("R9", 14'h0F0F);
      end
    end

    // R2: A15 set, and data present without strobe
    ioWrite(1, 1, 8'h1F);
    ioWrite(1, 1, 8'h7F);
    ioWrite(1, 1, 8'hBF);
    ioWrite(1, 2, 8'hC5);
    @(negedge clk);
    ioData = 8'hA5; ioAddr15 = 0;
    repeat (2) @(negedge clk);
    ioData = 8'hEA;
    repeat (2) @(negedge clk);
    verifyAll("R2");

    // R11: write and lookup of the same register in one cycle
    mapperMode = 1;
    @(negedge clk);
    ioWr = 1; ioAddrPage = 2'd2; ioData = {2'b11, 6'h2B};
    cpuAddr = {2'd2, 14'h0040};
    #1;
    chk("R11", 32'(physAddr[19:14]), 32'(expPage[2]));
    @(posedge clk); #1;
    chk("R11", 32'(physAddr[19:14]), 32'h2B);
    @(negedge clk);
    ioWr = 0;
    modelApply(0, 2'd2, {2'b11, 6'h2B});
    ioWrite(0, 0, 8'h03);
    @(negedge clk);
    ioWr = 1; ioData = {2'b01, 6'h2D};
    palRdIdx = 5'd3;
    #1;
    chk("R11", 32'(palRgb), 32'(expPal[3]));
    @(posedge clk); #1;
    chk("R11", 32'(palRgb), 32'h2D);
    @(negedge clk);
    ioWr = 0;
    modelApply(0, 0, {2'b01, 6'h2D});
    verifyAll("R11");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule